// File: doc/BRIEF.md
# Three-Channel Reloading Down-Counter Timer

This block holds three independent down-counters behind a small word-addressed register port. Each channel has a counter, a reload constant and a control word. The control word picks the count source and holds an underflow interrupt enable and a sticky underflow flag. The count source is a prescaled peripheral-clock enable, an RTC tick or an external tick. One shared start register carries one run bit per channel.

A running channel decrements once per tick from its selected source. When a tick arrives while the counter is already zero, the counter reloads from its constant instead of wrapping, and the underflow flag is set. The channel's interrupt line is the flag gated by the enable. Software clears the flag by writing a zero to it.

Reads are combinational from the current address. Writes take effect at the next rising clock edge while `regWe` is high.

Top module: `tmr3`

## Requirements
- R1: After reset every register reads zero, all channels are stopped, and `irq` and `badSel` are low.
- R2: Register layout (byte addresses):
  - Start register: at 0x00, where bit n runs channel n.
  - Channel n: the reload constant is at 0x04+12n, the counter at 0x08+12n and the control word at 0x0C+12n.
  - Control word fields: bits 2:0 select the source, bit 5 is the interrupt enable and bit 8 is the underflow flag. All other control bits read zero.
- R3: Source codes 0 to 4 give one decrement per 4, 16, 64, 256 or 1024 cycles with `pclkEn` high. Cycles with `pclkEn` low do not count.
- R4: Source code 5 is illegal. It drives that channel's `badSel` bit high and counts one decrement per 4096 `pclkEn` cycles.
- R5: Source code 6 decrements once per cycle with `rtcTick` high. Source code 7 decrements once per cycle with `extTick` high. The unselected tick input has no effect.
- R6: A tick arriving at a counter value of zero loads the reload constant and sets the underflow flag.
- R7: `irq[n]` is high exactly while channel n's underflow flag and interrupt enable are both set.
- R8: Writing 0 to the flag bit clears it and writing 1 leaves it unchanged. An underflow in the same cycle as a clearing write leaves the flag set.
- R9: A stopped channel holds its counter. Starting a channel restarts its prescaler, so the first decrement comes a full prescale period after the start edge.
- R10: A counter write in the same cycle as a tick stores the written value. That tick is discarded and causes no underflow.
- R11: Running one channel leaves the counters of the other channels unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWe | input | 1 | Register write strobe |
| regAddr | input | ADDR_W | Byte address for reads and writes |
| regWdata | input | CNT_W | Write data |
| regRdata | output | CNT_W | Read data for `regAddr` |
| pclkEn | input | 1 | Peripheral-clock enable feeding the prescalers |
| rtcTick | input | 1 | RTC tick, source code 6 |
| extTick | input | 1 | External tick, source code 7 |
| irq | output | NUM_CH | Per-channel underflow interrupt level |
| badSel | output | NUM_CH | Per-channel illegal source code indicator |

## Verification
The bench builds the block with its defaults: three channels, 32-bit counters and a 6-bit address. This lets it exercise the full register map and compare channels against one another for independence. Small reload and counter values keep underflow reachable within a few ticks. The 12-bit prescaler keeps even the 4096-cycle illegal-code period within a few thousand cycles, so every prescale ratio is checked at the exact edge where the decrement lands.

// File: rtl/tmr3_pkg.sv
package tmr3_pkg;
  localparam int START_OFS = 0;
  localparam int CH_BASE   = 4;
  localparam int CH_STRIDE = 12;
  localparam int CONST_OFS = 0;
  localparam int COUNT_OFS = 4;
  localparam int CTRL_OFS  = 8;
  localparam int BIT_IE    = 5;
  localparam int BIT_UF    = 8;
  localparam int PRESC_W   = 12;

  typedef struct packed {
    logic wrConst;
    logic wrCount;
    logic wrCtrl;
    logic tick;
  } chStrobe_t;
endpackage

// File: rtl/tmr3_ctrl.sv
module tmr3_ctrl
  import tmr3_pkg::*;
#(
  parameter int NUM_CH = 3,
  parameter int ADDR_W = 6
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         regWe,
  input  logic [ADDR_W-1:0]            regAddr,
  input  logic                         pclkEn,
  input  logic                         rtcTick,
  input  logic                         extTick,
  input  logic [NUM_CH-1:0]            run,
  input  logic [NUM_CH-1:0][2:0]       selCode,
  output logic                         wrStart,
  output chStrobe_t [NUM_CH-1:0]       strb
);
  assign wrStart = regWe && (regAddr == ADDR_W'(START_OFS));

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    localparam int BASE = CH_BASE + CH_STRIDE * ch;
    logic [PRESC_W-1:0] prescCnt;
    logic [PRESC_W-1:0] prescLast;
    logic               prescHit;
    chStrobe_t          s;

    always_comb begin
      if (selCode[ch] == 3'd5) prescLast = '1;
      else prescLast = (PRESC_W'(4) << {selCode[ch], 1'b0}) - PRESC_W'(1);
    end

    assign prescHit = pclkEn && (prescCnt >= prescLast);

    always_ff @(posedge clk) begin
      if (!rstN)           prescCnt <= '0;
      else if (!run[ch])   prescCnt <= '0;
      else if (pclkEn)     prescCnt <= prescHit ? '0 : prescCnt + PRESC_W'(1);
    end

    always_comb begin
      s.wrConst = regWe && (regAddr == ADDR_W'(BASE + CONST_OFS));
      s.wrCount = regWe && (regAddr == ADDR_W'(BASE + COUNT_OFS));
      s.wrCtrl  = regWe && (regAddr == ADDR_W'(BASE + CTRL_OFS));
      case (selCode[ch])
        3'd6:    s.tick = run[ch] && rtcTick;
        3'd7:    s.tick = run[ch] && extTick;
        default: s.tick = run[ch] && prescHit;
      endcase
    end

    assign strb[ch] = s;
  end
endmodule

// File: rtl/tmr3_dp.sv
module tmr3_dp
  import tmr3_pkg::*;
#(
  parameter int NUM_CH = 3,
  parameter int CNT_W  = 32
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic [CNT_W-1:0]              regWdata,
  input  logic                          wrStart,
  input  chStrobe_t [NUM_CH-1:0]        strb,
  output logic [NUM_CH-1:0]             run,
  output logic [NUM_CH-1:0][2:0]        selCode,
  output logic [NUM_CH-1:0]             irq,
  output logic [NUM_CH-1:0]             badSel,
  output logic [NUM_CH-1:0][CNT_W-1:0]  cntVal,
  output logic [NUM_CH-1:0][CNT_W-1:0]  constVal,
  output logic [NUM_CH-1:0][CNT_W-1:0]  ctrlVal
);
  logic [NUM_CH-1:0] runQ;

  always_ff @(posedge clk) begin
    if (!rstN)        runQ <= '0;
    else if (wrStart) runQ <= regWdata[NUM_CH-1:0];
  end
  assign run = runQ;

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    logic [CNT_W-1:0] cntQ;
    logic [CNT_W-1:0] constQ;
    logic [2:0]       codeQ;
    logic             ieQ;
    logic             ufQ;
    logic             ufEvent;
    logic [CNT_W-1:0] ctrlWord;

    assign ufEvent = strb[ch].tick && !strb[ch].wrCount && (cntQ == '0);

    always_ff @(posedge clk) begin
      if (!rstN) begin
        cntQ   <= '0;
        constQ <= '0;
        codeQ  <= '0;
        ieQ    <= 1'b0;
        ufQ    <= 1'b0;
      end else begin
        if (strb[ch].wrConst) constQ <= regWdata;
        if (strb[ch].wrCount)   cntQ <= regWdata;
        else if (ufEvent)       cntQ <= constQ;
        else if (strb[ch].tick) cntQ <= cntQ - CNT_W'(1);
        if (strb[ch].wrCtrl) begin
          codeQ <= regWdata[2:0];
          ieQ   <= regWdata[BIT_IE];
        end
        if (ufEvent)              ufQ <= 1'b1;
        else if (strb[ch].wrCtrl) ufQ <= ufQ & regWdata[BIT_UF];
      end
    end

    always_comb begin
      ctrlWord         = '0;
      ctrlWord[2:0]    = codeQ;
      ctrlWord[BIT_IE] = ieQ;
      ctrlWord[BIT_UF] = ufQ;
    end

    assign cntVal[ch]   = cntQ;
    assign constVal[ch] = constQ;
    assign ctrlVal[ch]  = ctrlWord;
    assign selCode[ch]  = codeQ;
    assign irq[ch]      = ufQ & ieQ;
    assign badSel[ch]   = (codeQ == 3'd5);
  end
endmodule

// File: rtl/tmr3.sv
module tmr3
  import tmr3_pkg::*;
#(
  parameter int NUM_CH = 3,
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [CNT_W-1:0]  regWdata,
  output logic [CNT_W-1:0]  regRdata,
  input  logic              pclkEn,
  input  logic              rtcTick,
  input  logic              extTick,
  output logic [NUM_CH-1:0] irq,
  output logic [NUM_CH-1:0] badSel
);
  logic                         wrStart;
  chStrobe_t [NUM_CH-1:0]       strb;
  logic [NUM_CH-1:0]            run;
  logic [NUM_CH-1:0][2:0]       selCode;
  logic [NUM_CH-1:0][CNT_W-1:0] cntVal;
  logic [NUM_CH-1:0][CNT_W-1:0] constVal;
  logic [NUM_CH-1:0][CNT_W-1:0] ctrlVal;

  tmr3_ctrl #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .pclkEn(pclkEn), .rtcTick(rtcTick), .extTick(extTick),
    .run(run), .selCode(selCode), .wrStart(wrStart), .strb(strb)
  );

  tmr3_dp #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .regWdata(regWdata), .wrStart(wrStart),
    .strb(strb), .run(run), .selCode(selCode), .irq(irq),
    .badSel(badSel), .cntVal(cntVal), .constVal(constVal), .ctrlVal(ctrlVal)
  );

  always_comb begin
    regRdata = '0;
    if (regAddr == ADDR_W'(START_OFS)) regRdata[NUM_CH-1:0] = run;
    for (int i = 0; i < NUM_CH; i++) begin
      if (regAddr == ADDR_W'(CH_BASE + CH_STRIDE * i + CONST_OFS)) regRdata = constVal[i];
      if (regAddr == ADDR_W'(CH_BASE + CH_STRIDE * i + COUNT_OFS)) regRdata = cntVal[i];
      if (regAddr == ADDR_W'(CH_BASE + CH_STRIDE * i + CTRL_OFS))  regRdata = ctrlVal[i];
    end
  end
endmodule

// File: rtl/tmr3_chk.sv
module tmr3_chk
  import tmr3_pkg::*;
#(
  parameter int NUM_CH = 3,
  parameter int CNT_W  = 32
) (
  input logic                         clk,
  input logic                         rstN,
  input logic [CNT_W-1:0]             regWdata,
  input logic [NUM_CH-1:0]            run,
  input chStrobe_t [NUM_CH-1:0]       strb,
  input logic [NUM_CH-1:0]            irq,
  input logic [NUM_CH-1:0][CNT_W-1:0] cntVal,
  input logic [NUM_CH-1:0][CNT_W-1:0] constVal,
  input logic [NUM_CH-1:0][CNT_W-1:0] ctrlVal
);
  for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
    assert_const_write_R2: assert property (@(posedge clk) disable iff (!rstN)
      strb[i].wrConst |=> constVal[i] == $past(regWdata));

    assert_tick_decrement_R3: assert property (@(posedge clk) disable iff (!rstN)
      (strb[i].tick && !strb[i].wrCount && cntVal[i] != '0)
      |=> cntVal[i] == $past(cntVal[i]) - CNT_W'(1));

    assert_underflow_reload_R6: assert property (@(posedge clk) disable iff (!rstN)
      (strb[i].tick && !strb[i].wrCount && cntVal[i] == '0)
      |=> (cntVal[i] == $past(constVal[i])) && ctrlVal[i][BIT_UF]);

    assert_irq_disabled_R7: assert property (@(posedge clk) disable iff (!rstN)
      (strb[i].wrCtrl && !regWdata[BIT_IE]) |=> !irq[i]);

    assert_stopped_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
      (!run[i] && !strb[i].wrCount) |=> $stable(cntVal[i]));

    assert_write_wins_R10: assert property (@(posedge clk) disable iff (!rstN)
      strb[i].wrCount |=> cntVal[i] == $past(regWdata));
  end
endmodule

bind tmr3 tmr3_chk #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rstN(rstN), .regWdata(regWdata), .run(run), .strb(strb),
  .irq(irq), .cntVal(cntVal), .constVal(constVal), .ctrlVal(ctrlVal)
);

// File: tb/sim_tmr3.sv
`timescale 1ns/1ps
module sim_tmr3;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWe = 1'b0;
  logic [5:0]  regAddr = '0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic        pclkEn = 1'b1;
  logic        rtcTick = 1'b0;
  logic        extTick = 1'b0;
  logic [2:0]  irq;
  logic [2:0]  badSel;

  int nChk = 0;
  int nFail = 0;

  always #2.5 clk = ~clk;

  tmr3 u0 (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .pclkEn(pclkEn),
    .rtcTick(rtcTick), .extTick(extTick), .irq(irq), .badSel(badSel)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chkReg(input string req, input int addr, input logic [31:0] exp);
    regAddr = 6'(addr);
    #1;
    chk(req, regRdata, exp);
  endtask

  task automatic wr(input int addr, input logic [31:0] data);
    @(negedge clk);
    regWe = 1'b1; regAddr = 6'(addr); regWdata = data;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic t_reset;
    chkReg("R1 start", 0, 0);
    for (int n = 0; n < 3; n++) begin
      chkReg("R1 const", 4 + 12 * n, 0);
      chkReg("R1 count", 8 + 12 * n, 0);
      chkReg("R1 ctrl", 12 + 12 * n, 0);
    end
    chk("R1 irq", {29'b0, irq}, 0);
    chk("R1 badSel", {29'b0, badSel}, 0);
  endtask

  task automatic t_layout;
    wr(16, 32'h1234);
    wr(32, 32'h55);
    wr(12, 32'hFFFF_FFFF);
    chkReg("R2 const ch1", 16, 32'h1234);
    chkReg("R2 count ch2", 32, 32'h55);
    chkReg("R2 R8 ctrl mask", 12, 32'h27);
    wr(12, 0);
    wr(32, 0);
  endtask

  task automatic t_prescale(input string req, input int code, input int ratio, input int m);
    wr(12, code);
    wr(4, 100);
    wr(8, 100);
    wr(0, 1);
    if (code == 5) chk("R4 badSel", {29'b0, badSel}, 1);
    repeat (ratio * m - 1) @(negedge clk);
    chkReg(req, 8, 100 - (m - 1));
    @(negedge clk);
    chkReg(req, 8, 100 - m);
    wr(0, 0);
  endtask

  task automatic t_gate;
    wr(12, 0);
    wr(8, 50);
    pclkEn = 1'b0;
    wr(0, 1);
    repeat (40) @(negedge clk);
    chkReg("R3 gated", 8, 50);
    pclkEn = 1'b1;
    repeat (3) @(negedge clk);
    chkReg("R3 resume", 8, 50);
    @(negedge clk);
    chkReg("R3 resume", 8, 49);
    wr(0, 0);
  endtask

  task automatic t_restart;
    wr(12, 1);
    wr(8, 50);
    wr(0, 1);
    repeat (10) @(negedge clk);
    wr(0, 0);
    chkReg("R9 partial", 8, 50);
    repeat (100) @(negedge clk);
    chkReg("R9 hold", 8, 50);
    wr(0, 1);
    repeat (15) @(negedge clk);
    chkReg("R9 fresh phase", 8, 50);
    @(negedge clk);
    chkReg("R9 fresh phase", 8, 49);
    wr(0, 0);
  endtask

  task automatic t_sources;
    wr(24, 6);
    wr(16, 5);
    wr(20, 3);
    wr(0, 2);
    rtcTick = 1'b1;
    repeat (2) @(negedge clk);
    rtcTick = 1'b0;
    chkReg("R5 rtc", 20, 1);
    extTick = 1'b1;
    repeat (5) @(negedge clk);
    extTick = 1'b0;
    chkReg("R5 ext ignored", 20, 1);
    wr(24, 7);
    rtcTick = 1'b1;
    repeat (3) @(negedge clk);
    rtcTick = 1'b0;
    chkReg("R5 rtc ignored", 20, 1);
    extTick = 1'b1;
    @(negedge clk);
    extTick = 1'b0;
    chkReg("R5 ext", 20, 0);
  endtask

  task automatic t_underflow;
    wr(24, 32'h27);
    extTick = 1'b1;
    @(negedge clk);
    extTick = 1'b0;
    chkReg("R6 reload", 20, 5);
    chkReg("R6 flag", 24, 32'h127);
    chk("R7 irq on", {29'b0, irq}, 3'b010);
    wr(24, 32'h107);
    chk("R7 irq masked", {29'b0, irq}, 0);
    chkReg("R8 write one keeps", 24, 32'h107);
    wr(24, 32'h127);
    chk("R7 irq again", {29'b0, irq}, 3'b010);
    wr(24, 32'h27);
    chkReg("R8 clear", 24, 32'h27);
    chk("R8 irq cleared", {29'b0, irq}, 0);
    wr(20, 0);
    @(negedge clk);
    regWe = 1'b1; regAddr = 6'd24; regWdata = 32'h27; extTick = 1'b1;
    @(negedge clk);
    regWe = 1'b0; extTick = 1'b0;
    chkReg("R8 set wins", 24, 32'h127);
    chkReg("R6 reload same cycle", 20, 5);
  endtask

  task automatic t_writeWins;
    wr(24, 32'h27);
    wr(20, 0);
    @(negedge clk);
    regWe = 1'b1; regAddr = 6'd20; regWdata = 9; extTick = 1'b1;
    @(negedge clk);
    regWe = 1'b0; extTick = 1'b0;
    chkReg("R10 write at zero", 20, 9);
    chkReg("R10 no underflow", 24, 32'h27);
    chk("R10 irq", {29'b0, irq}, 0);
    @(negedge clk);
    regWe = 1'b1; regAddr = 6'd20; regWdata = 32'h40; extTick = 1'b1;
    @(negedge clk);
    regWe = 1'b0; extTick = 1'b0;
    chkReg("R10 write wins", 20, 32'h40);
    wr(0, 0);
  endtask

  task automatic t_indep;
    wr(36, 0);
    wr(32, 20);
    wr(8, 77);
    wr(0, 4);
    repeat (40) @(negedge clk);
    chkReg("R11 ch2 runs", 32, 10);
    chkReg("R11 ch0 untouched", 8, 77);
    chkReg("R11 ch1 untouched", 20, 32'h40);
    wr(0, 0);
  endtask

  initial begin
    #(5.0 * 150000);
    nFail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nFail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_layout();
    t_prescale("R3 code0", 0, 4, 3);
    t_prescale("R3 code1", 1, 16, 3);
    t_prescale("R3 code2", 2, 64, 3);
    t_prescale("R3 code3", 3, 256, 3);
    t_prescale("R3 code4", 4, 1024, 3);
    t_prescale("R4 code5", 5, 4096, 2);
    t_gate();
    t_restart();
    t_sources();
    t_underflow();
    t_writeWins();
    t_indep();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nFail);
    $finish;
  end
endmodule